// File: doc/BRIEF.md
# Four-Phase Instruction Cycle Sequencer

This block splits the system clock into a repeating instruction cycle of four equal phases, T1 to T4. Each phase lasts one clock and exactly one phase strobe is high at any time. The datapath uses the strobes to time its work. The program counter steps and the next instruction word is fetched in T1. The instruction fetched in the previous cycle is decoded and executed across T2 to T4, so the fetch of one instruction overlaps the execution of the one before it.

The branch and skip logic raises a redirect request in the last phase of an executing cycle when the program counter is about to be loaded with a non-sequential value. This covers jumps, calls, a direct write to the low program counter byte, and a skip whose condition holds. The sequencer then discards the instruction that was already prefetched. It marks the whole next cycle as a dummy, with the execute-valid flag low, while the correct instruction is fetched. A free-running phase pin can also be driven for external synchronisation. The pin is high for T1 and low for the other three phases, which gives one quarter of the clock rate at a 1:3 high/low duty. An enable input turns the pin off.

All pins are plain control and status signals. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `cycle_sequencer`

## Requirements
- R1: Exactly one bit of `phase_o` is high in every clock. The high bit steps T1 (bit 0) → T2 (bit 1) → T3 (bit 2) → T4 (bit 3) → T1, one position per clock.
- R2: While `rst_n` is low, and in the first clock after it rises, `phase_o` = 4'b0001 (T1), `fetch_stb` = 1, `exec_valid` = 0 and `t1_pin` = 0.
- R3: `fetch_stb` is high in T1 and low in T2, T3 and T4.
- R4: `exec_valid` is low for the whole first instruction cycle after reset and high in later cycles when no redirect occurs. It changes only on the clock edge that begins T1.
- R5: If `redirect_req` is high at the clock edge that ends T4 of a cycle with `exec_valid` high, the next instruction cycle is a dummy: `exec_valid` is low for all four phases. The cycle after the dummy executes again, with `exec_valid` high.
- R6: `redirect_req` sampled at the edges that end T1, T2 or T3 has no effect on `exec_valid`.
- R7: `redirect_req` sampled at the end of a dummy cycle (one with `exec_valid` low) is ignored, and the following cycle executes.
- R8: `t1_pin` is high during T1 of a cycle when `phase_pin_en` was high at the edge that ended the previous T4. It is low in T2, T3 and T4, which gives a 1:3 high/low duty at one quarter of the clock rate.
- R9: When `phase_pin_en` is low at the edge that ends T4, `t1_pin` stays low for the whole next instruction cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| redirect_req | input | 1 | Program counter redirect request from the branch/skip logic, sampled at the end of T4 |
| phase_pin_en | input | 1 | Enable for the external T1 phase pin |
| phase_o | output | 4 | One-hot phase strobes, bit 0 = T1 to bit 3 = T4 |
| fetch_stb | output | 1 | Fetch strobe, high in T1 |
| exec_valid | output | 1 | High for a cycle that executes a real instruction, low for the first cycle after reset and for dummy cycles |
| t1_pin | output | 1 | Registered T1 phase pin, 1:3 duty when enabled |

## Verification
The bench aims at the flush window. It raises a redirect at the end of T4 and expects exactly one dummy cycle. It also issues back-to-back redirects and sends a redirect during a dummy cycle; a design that chains flushes would lose a second cycle there. A redirect held through T1 to T3 must not flush anything; a design that samples it in the wrong phase would drop the wrong cycle or flush early. The first cycle after reset must show no execution, and a design that starts with execute-valid high would run an instruction that was never fetched. The phase pin is checked for its 1:3 shape and for turning off a whole cycle when the enable drops. A pin decoded in the wrong phase or with a wide pulse would show up as a duty error.

// File: rtl/cyc_seq_pkg.sv
package cyc_seq_pkg;
  localparam int unsigned NUM_PHASES  = 4;
  localparam int unsigned FETCH_PHASE = 0;
  localparam int unsigned LAST_PHASE  = NUM_PHASES - 1;
  typedef logic [NUM_PHASES-1:0] phase_vec_t;
endpackage

// File: rtl/phase_ring.sv
module phase_ring #(
  parameter int unsigned N = cyc_seq_pkg::NUM_PHASES
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [N-1:0] ph
);
  logic [N-1:0] ph_q;

  // One flop per phase; each takes the value of its predecessor.
  for (genvar i = 0; i < N; i++) begin : g_stage
    localparam int unsigned PREV = (i == 0) ? N - 1 : i - 1;
    localparam logic RST_VAL = (i == 0) ? 1'b1 : 1'b0;
    always_ff @(posedge clk) begin
      if (!rst_n) ph_q[i] <= RST_VAL;
      else        ph_q[i] <= ph_q[PREV];
    end
  end

  assign ph = ph_q;

  assert_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ph_q) == 1);
endmodule

// File: rtl/slot_tracker.sv
module slot_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic cycle_end,
  input  logic redirect_req,
  output logic exec_valid
);
  logic ev_q;

  // The slot for the next cycle is settled at the last phase.
  // A redirect from an executing cycle turns the prefetched slot into a dummy.
  // A dummy or empty slot is always followed by a real one.
  always_ff @(posedge clk) begin
    if (!rst_n)         ev_q <= 1'b0;
    else if (cycle_end) ev_q <= !(redirect_req && ev_q);
  end

  assign exec_valid = ev_q;

  assert_hold_mid_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cycle_end |=> $stable(ev_q));
  assert_flush_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_end && redirect_req && ev_q |=> !ev_q);
  assert_dummy_recovers_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_end && !ev_q |=> ev_q);
endmodule

// File: rtl/phase_pin_gen.sv
module phase_pin_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic cycle_end,
  input  logic pin_en,
  output logic pin
);
  logic pin_q;

  // Registered so the pad sees a clean flop output; it loads on the edge into T1.
  always_ff @(posedge clk) begin
    if (!rst_n) pin_q <= 1'b0;
    else        pin_q <= cycle_end && pin_en;
  end

  assign pin = pin_q;

  assert_pin_only_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cycle_end |=> !pin_q);
  assert_pin_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_end && !pin_en |=> !pin_q);
endmodule

// File: rtl/cycle_sequencer.sv
module cycle_sequencer
  import cyc_seq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  redirect_req,
  input  logic                  phase_pin_en,
  output logic [NUM_PHASES-1:0] phase_o,
  output logic                  fetch_stb,
  output logic                  exec_valid,
  output logic                  t1_pin
);
  phase_vec_t ph;
  logic       last_ph;

  phase_ring #(.N(NUM_PHASES)) u_ring (
    .clk   (clk),
    .rst_n (rst_n),
    .ph    (ph)
  );

  assign last_ph   = ph[LAST_PHASE];
  assign phase_o   = ph;
  assign fetch_stb = ph[FETCH_PHASE];

  slot_tracker u_slot (
    .clk          (clk),
    .rst_n        (rst_n),
    .cycle_end    (last_ph),
    .redirect_req (redirect_req),
    .exec_valid   (exec_valid)
  );

  phase_pin_gen u_pin (
    .clk       (clk),
    .rst_n     (rst_n),
    .cycle_end (last_ph),
    .pin_en    (phase_pin_en),
    .pin       (t1_pin)
  );

  assert_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    phase_o[LAST_PHASE] |=> phase_o[FETCH_PHASE]);
  assert_fetch_after_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fetch_stb) |-> $past(phase_o[LAST_PHASE]));
  assert_pin_in_fetch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    t1_pin |-> fetch_stb);
endmodule

// File: tb/tb_cycle_sequencer.sv
module tb_cycle_sequencer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       redirect_req = 1'b0;
  logic       phase_pin_en = 1'b0;
  logic [3:0] phase_o;
  logic       fetch_stb, exec_valid, t1_pin;

  int checks = 0;
  int bad = 0;
  bit done = 1'b0;

  typedef struct {
    logic [3:0] ph;
    logic       fe;
    logic       ev;
    logic       pin;
    string      ev_tag;
    string      pin_tag;
  } exp_t;
  exp_t q[$];

  int m_ph = 0;
  bit m_ev = 1'b0;
  bit m_pin = 1'b0;

  cycle_sequencer dut (
    .clk(clk), .rst_n(rst_n), .redirect_req(redirect_req),
    .phase_pin_en(phase_pin_en), .phase_o(phase_o), .fetch_stb(fetch_stb),
    .exec_valid(exec_valid), .t1_pin(t1_pin)
  );

  always #10 clk = ~clk;

  task automatic chk(string tag, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // Driver: one clock; applies inputs and queues the expected outputs after the edge.
  task automatic step(bit redir, bit en, string evt, string pint);
    exp_t e;
    redirect_req = redir;
    phase_pin_en = en;
    if (m_ph == 3) begin
      m_ev  = !(redir && m_ev);
      m_pin = en;
    end else begin
      m_pin = 1'b0;
    end
    m_ph = (m_ph + 1) % 4;
    e.ph = 4'b0001 << m_ph;
    e.fe = (m_ph == 0);
    e.ev = m_ev;
    e.pin = m_pin;
    e.ev_tag = evt;
    e.pin_tag = pint;
    q.push_back(e);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_cycle(bit redir_last, bit redir_other, bit en, string evt, string pint);
    for (int k = 0; k < 4; k++)
      step((k == 3) ? redir_last : redir_other, en, evt, pint);
  endtask

  // Monitor: compares every clock, away from the active edge.
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk("R1", phase_o, e.ph);
        chk("R3", {3'b0, fetch_stb}, {3'b0, e.fe});
        chk(e.ev_tag, {3'b0, exec_valid}, {3'b0, e.ev});
        chk(e.pin_tag, {3'b0, t1_pin}, {3'b0, e.pin});
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R2: reset state while held
    chk("R2", phase_o, 4'b0001);
    chk("R2", {3'b0, exec_valid}, 4'b0);
    chk("R2", {3'b0, t1_pin}, 4'b0);
    rst_n = 1'b1;
    // R2: first clock after release (nothing sampled yet)
    chk("R2", phase_o, 4'b0001);
    chk("R2", {3'b0, fetch_stb}, 4'b1);
    chk("R2", {3'b0, exec_valid}, 4'b0);

    run_cycle(0, 0, 1, "R4", "R8");   // first cycle: no execute
    run_cycle(0, 0, 1, "R4", "R8");
    run_cycle(1, 0, 1, "R5", "R8");   // redirect -> next is dummy
    run_cycle(0, 0, 1, "R5", "R8");   // dummy cycle, recovers
    run_cycle(0, 1, 1, "R6", "R8");   // redirect in T1..T3 ignored
    run_cycle(1, 0, 1, "R5", "R8");   // flush again
    run_cycle(1, 0, 1, "R7", "R8");   // redirect during dummy ignored
    run_cycle(1, 0, 0, "R5", "R9");   // back-to-back flush, pin off next cycle
    run_cycle(0, 1, 0, "R6", "R9");   // dummy, pin stays off
    run_cycle(0, 0, 1, "R4", "R8");   // pin resumes next cycle
    run_cycle(0, 0, 1, "R4", "R8");

    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule